// File: doc/BRIEF.md
# Transmit FIFO DMA Request Sequencer

This block drives the level-sensitive DMA request for a 32-entry transmit FIFO that is filled by a DMA controller working in demand transfer mode. Software or an upstream engine loads the byte count of the current block with a start strobe. The count is either a whole message or the rest of a long one. Once the FIFO reports room, the request goes high. The controller then writes bytes until the request falls. While the acknowledge is active, every write strobe lands on the top of the FIFO, whatever the chip select and address decode say. Without the acknowledge, a write is taken only when the chip select and the FIFO address decode are both active.

The request is pulled low one byte early: on the write of the second-to-last byte of a block, and also on every write whose index sits just below a 32-byte boundary. A slow controller stops exactly on time, and a fast one that has already started the next cycle still moves the correct number of bytes. After an early drop, the request comes back on the next rising edge of the acknowledge, or of the chip select with address decode, but only if bytes are still owed. When the whole block has been written, a done flag rises and the request stays low until the next start strobe.

All bus-side inputs are asynchronous to the block clock. Each passes through two flops, and edges are taken as single-cycle pulses in the block clock domain.

Top module: `txdma_req_seq`

## Requirements
- R1: After reset, `dreq_o`, `fifo_we_o` and `done_o` are all low.
- R2: A `start_i` pulse loads `len_i` and clears the byte count. For a nonzero length, `dreq_o` rises only once `fifo_room_i` is high and the synchronised write strobe is low. A length of zero sets `done_o` and never raises `dreq_o`.
- R3: With the synchronised acknowledge high, each rising edge of `wr_i` produces exactly one single-cycle `fifo_we_o` pulse, whatever the values of `cs_i` and `addr_hit_i`.
- R4: With the acknowledge low, a write strobe is taken only when `cs_i` and `addr_hit_i` are both high. If either is low, the strobe gives no `fifo_we_o` pulse and does not change `dreq_o`.
- R5: Writes are numbered 1 to n within a block of length n. For n of at least 2, `dreq_o` falls on write n-1. For n equal to 1, it falls on write 1.
- R6: For any write index k below n whose low five bits are all ones (k = 31, 63, 95, ...), `dreq_o` also falls.
- R7: After an early drop, a rising edge of the acknowledge, or of `cs_i` and `addr_hit_i` together, raises `dreq_o` again if bytes remain. Once the block is complete, such an edge leaves `dreq_o` low.
- R8: `done_o` rises when the write count reaches the loaded length. After that, write strobes give no `fifo_we_o` pulse until the next start.
- R9: Between drops, `dreq_o` stays high across writes that are neither the second-to-last byte nor at a boundary index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-block strobe, synchronous, one cycle |
| len_i | input | LEN_W | Byte count of the block, sampled on start_i |
| fifo_room_i | input | 1 | FIFO can accept a new block |
| dack_i | input | 1 | DMA acknowledge, asynchronous, active high |
| cs_i | input | 1 | Chip select, asynchronous, active high |
| addr_hit_i | input | 1 | Bus address decodes to the FIFO, active high |
| wr_i | input | 1 | Write strobe, asynchronous, active high |
| dreq_o | output | 1 | DMA request, level sensitive |
| fifo_we_o | output | 1 | One-cycle FIFO write enable per accepted write |
| done_o | output | 1 | Block fully transferred |

## Verification
If the byte count is corrupted, the request falls on the wrong write. The error shows at `dreq_o` within three clocks of the synchronised strobe of the affected byte, and a count past the length shows up as a surplus `fifo_we_o` pulse. If the hold state is entered or left wrongly, it appears as a request that fails to come back, or that comes back after completion, on the first acknowledge or select edge that follows. Sweeping every block length from 0 to 70 covers the final-byte drop at every position relative to the first two 32-byte boundaries, including lengths that end exactly on or just past a boundary.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_REQ,
    ST_HOLD,
    ST_DONE
  } req_st_e;
endpackage

// File: rtl/txdma_edge_sync.sv
module txdma_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~s3_q;

    assert_pulse_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/txdma_byte_cnt.sv
module txdma_byte_cnt #(
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             inc_i,
  output logic             remain_o,
  output logic             fin_o,
  output logic             early_o,
  output logic             bound_o
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CW    = LEN_W + 1;

  logic [LEN_W-1:0] cnt_q, len_q;
  logic [CW-1:0]    nxt, len_x;

  assign len_x    = {1'b0, len_q};
  assign nxt      = {1'b0, cnt_q} + CW'(1);
  assign remain_o = cnt_q < len_q;
  assign fin_o    = nxt == len_x;
  // write index nxt is the second-to-last (or last) byte
  assign early_o  = (nxt + CW'(1)) >= len_x;
  assign bound_o  = nxt[PTR_W-1:0] == {PTR_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      len_q <= len_i;
    end else if (inc_i && remain_o) begin
      cnt_q <= nxt[LEN_W-1:0];
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_q);
  assert_cnt_mono_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/txdma_req_fsm.sv
module txdma_req_fsm
  import txdma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic len_zero_i,
  input  logic raise_ok_i,
  input  logic we_i,
  input  logic fin_i,
  input  logic early_i,
  input  logic bound_i,
  input  logic reraise_i,
  output logic dreq_o,
  output logic active_o,
  output logic done_o
);
  req_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start_i) begin
      st_d = len_zero_i ? ST_DONE : ST_PEND;
    end else begin
      unique case (st_q)
        ST_PEND: if (raise_ok_i) st_d = ST_REQ;
        ST_REQ: begin
          if (we_i) begin
            if (fin_i)                 st_d = ST_DONE;
            else if (early_i || bound_i) st_d = ST_HOLD;
          end
        end
        ST_HOLD: begin
          // hold implies bytes remain unless this write finishes the block
          if (we_i && fin_i)  st_d = ST_DONE;
          else if (reraise_i) st_d = ST_REQ;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign dreq_o   = st_q == ST_REQ;
  assign active_o = (st_q == ST_REQ) || (st_q == ST_HOLD);
  assign done_o   = st_q == ST_DONE;

  assert_hold_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && $past(st_q) != ST_HOLD) |-> $past(we_i));
endmodule

// File: rtl/txdma_req_seq.sv
module txdma_req_seq #(
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             fifo_room_i,
  input  logic             dack_i,
  input  logic             cs_i,
  input  logic             addr_hit_i,
  input  logic             wr_i,
  output logic             dreq_o,
  output logic             fifo_we_o,
  output logic             done_o
);
  localparam int NCH    = 3;
  localparam int CH_WR  = 0;
  localparam int CH_ACK = 1;
  localparam int CH_SEL = 2;

  logic [NCH-1:0] async_in, lvl, rise;
  logic remain, fin, early, bound, active;
  logic wr_acc, we, reraise;

  assign async_in = {cs_i & addr_hit_i, dack_i, wr_i};

  txdma_edge_sync #(.N(NCH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(async_in),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  // acknowledge overrides select/address decode
  assign wr_acc  = rise[CH_WR] & (lvl[CH_ACK] | lvl[CH_SEL]);
  assign we      = wr_acc & active & remain;
  assign reraise = rise[CH_ACK] | rise[CH_SEL];

  txdma_byte_cnt #(.LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_i),
    .len_i   (len_i),
    .inc_i   (we),
    .remain_o(remain),
    .fin_o   (fin),
    .early_o (early),
    .bound_o (bound)
  );

  txdma_req_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .len_zero_i(len_i == '0),
    .raise_ok_i(fifo_room_i & ~lvl[CH_WR]),
    .we_i      (we),
    .fin_i     (fin),
    .early_i   (early),
    .bound_i   (bound),
    .reraise_i (reraise),
    .dreq_o    (dreq_o),
    .active_o  (active),
    .done_o    (done_o)
  );

  assign fifo_we_o = we;

  assert_drop_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dreq_o) |-> ($past(fifo_we_o) || $past(start_i)));
  assert_rise_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dreq_o) |-> ($past(reraise) || $past(fifo_room_i)));
  assert_done_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(fifo_we_o) || $past(start_i)));
  assert_we_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |=> !fifo_we_o);
endmodule

// File: tb/txdma_req_seq_tb.sv
module txdma_req_seq_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, fifo_room_i = 1'b1;
  logic dack_i = 1'b0, cs_i = 1'b0, addr_hit_i = 1'b0, wr_i = 1'b0;
  logic [7:0] len_i = '0;
  logic dreq_o, fifo_we_o, done_o;

  int n_chk = 0, n_fail = 0, we_cnt = 0, cyc = 0;
  int blk_n = 0, blk_k = 0, exp_req = 0, exp_done = 0;

  always #5 clk = ~clk;

  txdma_req_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .fifo_room_i(fifo_room_i), .dack_i(dack_i), .cs_i(cs_i),
    .addr_hit_i(addr_hit_i), .wr_i(wr_i),
    .dreq_o(dreq_o), .fifo_we_o(fifo_we_o), .done_o(done_o)
  );

  always @(negedge clk) if (rst_ni && fifo_we_o) we_cnt++;

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
      report();
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (len %0d, write %0d)",
               tag, act, exp, blk_n, blk_k);
    end
  endtask

  task automatic wait_n(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic start_blk(int n);
    @(negedge clk);
    len_i = 8'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_n(4);
    blk_n = n; blk_k = 0;
    exp_req  = (n > 0 && fifo_room_i) ? 1 : 0;
    exp_done = (n == 0) ? 1 : 0;
    chk("R2 dreq after start", int'(dreq_o), exp_req);
    chk("R2 done after start", int'(done_o), exp_done);
  endtask

  // one controller cycle: strobe-select edge, then a write strobe
  task automatic xfer(bit use_ack);
    int we0, exp_we;
    string tag;
    @(negedge clk);
    if (use_ack) dack_i = 1'b1;
    else begin cs_i = 1'b1; addr_hit_i = 1'b1; end
    wait_n(5);
    if (!exp_done && exp_req == 0) exp_req = 1;
    chk("R7 dreq after select edge", int'(dreq_o), exp_req);
    we0 = we_cnt;
    wr_i = 1'b1;
    wait_n(5);
    tag = "R9 dreq level";
    exp_we = 0;
    if (exp_done == 0) begin
      blk_k++;
      exp_we = 1;
      if (blk_k == blk_n) begin
        exp_done = 1; exp_req = 0; tag = "R5 dreq final";
      end else if (exp_req == 1 && blk_k >= blk_n - 1) begin
        exp_req = 0; tag = "R5 dreq early";
      end else if (exp_req == 1 && (blk_k % 32) == 31) begin
        exp_req = 0; tag = "R6 dreq boundary";
      end
    end
    chk(exp_we ? "R3 we pulse" : "R8 no we after done", we_cnt - we0, exp_we);
    chk(tag, int'(dreq_o), exp_req);
    chk("R8 done", int'(done_o), exp_done);
    wr_i = 1'b0; dack_i = 1'b0; cs_i = 1'b0; addr_hit_i = 1'b0;
    wait_n(4);
  endtask

  task automatic raw_write(bit d, bit c, bit a, int exp_we, string tag);
    int we0;
    @(negedge clk);
    dack_i = d; cs_i = c; addr_hit_i = a;
    wait_n(4);
    we0 = we_cnt;
    wr_i = 1'b1;
    wait_n(5);
    chk(tag, we_cnt - we0, exp_we);
    chk({tag, " dreq"}, int'(dreq_o), 1);
    wr_i = 1'b0; dack_i = 1'b0; cs_i = 1'b0; addr_hit_i = 1'b0;
    wait_n(4);
  endtask

  initial begin
    wait_n(3);
    chk("R1 dreq reset", int'(dreq_o), 0);
    chk("R1 we reset", int'(fifo_we_o), 0);
    chk("R1 done reset", int'(done_o), 0);
    @(negedge clk) rst_ni = 1'b1;
    wait_n(3);
    chk("R1 dreq idle", int'(dreq_o), 0);

    // R2: request waits for FIFO room
    fifo_room_i = 1'b0;
    start_blk(5);
    wait_n(6);
    chk("R2 held without room", int'(dreq_o), 0);
    fifo_room_i = 1'b1;
    wait_n(5);
    exp_req = 1;
    chk("R2 raised with room", int'(dreq_o), 1);
    for (int i = 0; i < 6; i++) xfer(1'b1);

    // R4 / R3: select qualification
    start_blk(10);
    raw_write(1'b0, 1'b1, 1'b0, 0, "R4 cs without addr ignored");
    raw_write(1'b0, 1'b0, 1'b1, 0, "R4 addr without cs ignored");
    raw_write(1'b0, 1'b1, 1'b1, 1, "R4 cs and addr accepted");
    raw_write(1'b1, 1'b0, 1'b0, 1, "R3 ack ignores cs and addr");
    blk_k = 2;
    for (int i = 0; i < 9; i++) xfer(1'b1);

    // sweep every length with acknowledge-driven writes, one extra write
    for (int n = 0; n <= 70; n++) begin
      start_blk(n);
      for (int i = 0; i <= n; i++) xfer(1'b1);
    end

    // addressed writes with select edges re-raising the request
    foreach (blk_len_set[j]) begin
      start_blk(blk_len_set[j]);
      for (int i = 0; i <= blk_len_set[j]; i++) xfer(1'b0);
    end

    report();
  end

  int blk_len_set[8] = '{1, 2, 3, 31, 32, 33, 64, 65};
endmodule